// File: doc/BRIEF.md
# FIFO Read Controller with Fall-Through and Rewind

This block is the storage, pointer and read-side control of a single-clock synchronous FIFO. It has two output timing behaviours, chosen once when master reset is applied. In standard timing a stored word moves to the output register only when the reader asks for it. In fall-through timing the oldest stored word moves to the output register without being asked, and a read enable consumes it. The two status outputs change meaning with the timing mode. In standard timing they are empty and full. In fall-through timing they are output-ready and input-ready.

A rewind request sends the read pointer back to the first memory location, so the words written since the last reset can be read again. A rewind has one of two latencies, also fixed at master reset. With normal latency the output register keeps its value on the rewind edge. With zero latency the first word is placed in the output register on that same edge. A partial reset clears both pointers and the output register but keeps the timing mode and the rewind latency. Rewind is defined only while no more than DEPTH words have been written since the last reset.

Top module: `sfifo_rdctl`

## Requirements
- R1: A clock edge with `mrst` high empties the FIFO and clears `rd_data` to 0. On that edge the block captures `cfg_fwft` (1 = fall-through timing) and `cfg_rt_zero` (1 = zero-latency rewind). After the edge, standard timing shows `flag_out`=1 and `flag_in`=0, and fall-through timing shows `flag_out`=0 and `flag_in`=1.
- R2: In standard timing, an edge with `rd_en`=1 while the FIFO holds at least one word loads the oldest word onto `rd_data`. Words come out in write order. Without such a read, `rd_data` holds its value.
- R3: In standard timing, `flag_out` is 1 exactly when zero words are stored, and `flag_in` is 1 exactly when DEPTH words are stored.
- R4: In fall-through timing, a word written into an empty FIFO appears on `rd_data` with `flag_out`=1 after the edge that follows the write edge, with `rd_en` held low.
- R5: In fall-through timing, an edge with `rd_en`=1 and `flag_out`=1 consumes the displayed word. On that same edge the next stored word is displayed, or `flag_out` falls if no word is stored. `flag_in` is 1 while fewer than DEPTH words are held, and the displayed word counts as held.
- R6: A write on an edge where the FIFO is full before that edge is dropped and never appears at the output. A read while nothing is available leaves `rd_data` and the flags unchanged.
- R7: Normal-latency rewind: an edge with `rt_req`=1 leaves `rd_data` unchanged and sets the read position back to the first word written since reset. In standard timing the next read returns that word. In fall-through timing `flag_out` is 0 after the rewind edge, and that word is displayed after the following edge.
- R8: Zero-latency rewind: the edge with `rt_req`=1 places the first word written since reset on `rd_data`, with `flag_out`=1 in fall-through timing. Later reads continue from the second word.
- R9: A clock edge with `prst` high empties the FIFO and clears `rd_data`, while the timing mode and the rewind latency stay as they were.
- R10: When `rt_req` and `rd_en` are both high on one edge, the rewind takes effect and the read is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst | input | 1 | Synchronous master reset, active high; captures the configuration |
| prst | input | 1 | Synchronous partial reset, active high; keeps the configuration |
| cfg_fwft | input | 1 | Timing mode sampled at master reset: 1 fall-through, 0 standard |
| cfg_rt_zero | input | 1 | Rewind latency sampled at master reset: 1 zero, 0 normal |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Rewind request |
| rd_data | output | W | Output register |
| flag_out | output | 1 | Empty (standard) or output-ready (fall-through) |
| flag_in | output | 1 | Full (standard) or input-ready (fall-through) |

## Verification
A wrong read pointer shows up on `rd_data` at the first read that follows it, because the returned word does not match the head of the scoreboard queue. A wrong occupancy shows up in the flags on the edge after the bad update, either as a full or empty indication that comes too early or as one that never comes. A lost or stale valid bit in fall-through timing shows up one cycle after a write or a read, as `flag_out` disagreeing with the number of words still expected. A rewind that restarts from the wrong location shows up on the first word read after the rewind.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Configuration captured on a master-reset edge.
    typedef struct packed {
        logic fwft;      // 1: fall-through timing, 0: standard timing
        logic rt_zero;   // 1: zero-latency rewind, 0: normal latency
    } sfifo_cfg_t;

endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/sfifo_wptr.sv
module sfifo_wptr #(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        wr_en,
    input  logic        full,
    output logic [AW:0] wptr,
    output logic        we
);
    localparam int PTR_W = AW + 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (clr) begin
            st_d.ptr = '0;
        end else if (wr_en && !full) begin
            we       = 1'b1;
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wptr = st_q.ptr;
endmodule

// File: rtl/sfifo_rdpath.sv
module sfifo_rdpath #(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          fwft,
    input  logic          rt_zero,
    input  logic          rd_en,
    input  logic          rt_req,
    input  logic [AW:0]   mem_cnt,
    input  logic          any_wr,
    input  logic [W-1:0]  rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr,
    output logic [W-1:0]  dout,
    output logic          valid
);
    localparam int PTR_W = AW + 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [W-1:0]     word;
        logic             vld;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   mem_has;

    always_comb begin
        st_d    = st_q;
        raddr   = st_q.ptr[AW-1:0];
        mem_has = (mem_cnt != '0);
        if (clr) begin
            st_d = '0;
        end else if (rt_req) begin
            // Rewind wins over a read on the same edge.
            if (rt_zero && any_wr) begin
                raddr     = '0;
                st_d.word = rdata;
                st_d.ptr  = PTR_W'(1);
                st_d.vld  = fwft;
            end else begin
                st_d.ptr = '0;
                if (fwft) begin
                    st_d.vld = 1'b0;
                end
            end
        end else if (fwft) begin
            if (mem_has && (!st_q.vld || rd_en)) begin
                st_d.word = rdata;
                st_d.ptr  = st_q.ptr + PTR_W'(1);
                st_d.vld  = 1'b1;
            end else if (rd_en) begin
                st_d.vld = 1'b0;
            end
        end else if (rd_en && mem_has) begin
            st_d.word = rdata;
            st_d.ptr  = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rptr  = st_q.ptr;
    assign dout  = st_q.word;
    assign valid = st_q.vld;
endmodule

// File: rtl/sfifo_rdctl.sv
module sfifo_rdctl
    import sfifo_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 3
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic         prst,
    input  logic         cfg_fwft,
    input  logic         cfg_rt_zero,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         rt_req,
    output logic [W-1:0] rd_data,
    output logic         flag_out,
    output logic         flag_in
);
    localparam int DEPTH = 1 << AW;
    localparam int PTR_W = AW + 1;

    typedef struct packed {
        sfifo_cfg_t cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             clr;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] mem_cnt;
    logic [PTR_W-1:0] occ;
    logic             full;
    logic             we;
    logic             valid;
    logic [AW-1:0]    raddr;
    logic [W-1:0]     rdata;
    logic             mode_fwft;
    logic             mode_rtz;

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.cfg.fwft    = cfg_fwft;
            st_d.cfg.rt_zero = cfg_rt_zero;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_fwft = st_q.cfg.fwft;
    assign mode_rtz  = st_q.cfg.rt_zero;
    assign clr       = mrst | prst;
    assign mem_cnt   = wptr - rptr;
    assign occ       = mem_cnt + {{AW{1'b0}}, (mode_fwft & valid)};
    assign full      = (occ == PTR_W'(DEPTH));
    assign flag_out  = mode_fwft ? valid : (mem_cnt == '0);
    assign flag_in   = mode_fwft ? !full : full;

    sfifo_wptr #(.AW(AW)) u_wptr (
        .clk   (clk),
        .clr   (clr),
        .wr_en (wr_en),
        .full  (full),
        .wptr  (wptr),
        .we    (we)
    );

    sfifo_mem #(.W(W), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    sfifo_rdpath #(.W(W), .AW(AW)) u_rd (
        .clk     (clk),
        .clr     (clr),
        .fwft    (mode_fwft),
        .rt_zero (mode_rtz),
        .rd_en   (rd_en),
        .rt_req  (rt_req),
        .mem_cnt (mem_cnt),
        .any_wr  (wptr != '0),
        .rdata   (rdata),
        .raddr   (raddr),
        .rptr    (rptr),
        .dout    (rd_data),
        .valid   (valid)
    );
endmodule

module sfifo_rdctl_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         mrst,
    input logic         prst,
    input logic         wr_en,
    input logic         rd_en,
    input logic         rt_req,
    input logic [W-1:0] rd_data,
    input logic         flag_out,
    input logic         flag_in,
    input logic         mode_fwft,
    input logic         mode_rtz
);
    // R9: after a partial reset the FIFO reads as empty in the kept mode.
    assert_prst_empty_R9: assert property (@(posedge clk) disable iff (mrst)
        prst |=> (mode_fwft ? (!flag_out && flag_in) : (flag_out && !flag_in)) && rd_data == '0);

    // R6: a dropped write in standard timing leaves the FIFO full.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (mrst)
        (!mode_fwft && flag_in && wr_en && !rd_en && !rt_req && !prst) |=> flag_in);

    // R6: a read of an empty FIFO in standard timing keeps the output.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (mrst)
        (!mode_fwft && flag_out && rd_en && !rt_req && !prst) |=> ($stable(rd_data) && flag_out));

    // R5: in fall-through timing a displayed word stays until consumed.
    assert_fwft_hold_R5: assert property (@(posedge clk) disable iff (mrst)
        (mode_fwft && flag_out && !rd_en && !rt_req && !prst) |=> (flag_out && $stable(rd_data)));

    // R7: a normal-latency rewind in fall-through timing drops output-ready.
    assert_rt_normal_R7: assert property (@(posedge clk) disable iff (mrst)
        (mode_fwft && !mode_rtz && rt_req && !prst) |=> !flag_out);
endmodule

bind sfifo_rdctl sfifo_rdctl_chk #(.W(W)) u_chk (
    .clk       (clk),
    .mrst      (mrst),
    .prst      (prst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rt_req    (rt_req),
    .rd_data   (rd_data),
    .flag_out  (flag_out),
    .flag_in   (flag_in),
    .mode_fwft (mode_fwft),
    .mode_rtz  (mode_rtz)
);

// File: tb/sfifo_rdctl_tb.sv
module sfifo_rdctl_tb;
    localparam int W     = 16;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic         clk = 1'b0;
    logic         mrst = 1'b1;
    logic         prst = 1'b0;
    logic         cfg_fwft = 1'b0;
    logic         cfg_rt_zero = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         rt_req = 1'b0;
    logic [W-1:0] rd_data;
    logic         flag_out;
    logic         flag_in;

    int n_chk = 0;
    int n_bad = 0;
    int occ = 0;
    logic [W-1:0] exp_q [$];
    logic [W-1:0] hist  [$];
    logic [W-1:0] last_word = '0;

    always #5 clk = ~clk;

    sfifo_rdctl #(.W(W), .AW(AW)) u_dut (
        .clk, .mrst, .prst, .cfg_fwft, .cfg_rt_zero,
        .wr_en, .wr_data, .rd_en, .rt_req,
        .rd_data, .flag_out, .flag_in
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_mrst(input logic f, input logic z);
        cfg_fwft = f; cfg_rt_zero = z; mrst = 1'b1;
        tick();
        mrst = 1'b0;
        exp_q.delete(); hist.delete(); occ = 0; last_word = '0;
    endtask

    task automatic do_prst();
        prst = 1'b1;
        tick();
        prst = 1'b0;
        exp_q.delete(); hist.delete(); occ = 0; last_word = '0;
    endtask

    // Driver: pushes accepted words into the scoreboard.
    task automatic do_wr(input logic [W-1:0] d);
        bit acc;
        acc = (occ < DEPTH);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
        if (acc) begin
            exp_q.push_back(d); hist.push_back(d); occ++;
        end
    endtask

    // Monitor for standard timing: pop and compare the loaded word.
    task automatic rd_std(input string tag);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        if (occ > 0) begin
            last_word = exp_q.pop_front(); occ--;
        end
        chk(tag, rd_data, last_word);
    endtask

    // Monitor for fall-through timing: consume and compare the next head.
    task automatic rd_fw(input string tag);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        if (occ > 0) begin
            void'(exp_q.pop_front()); occ--;
        end
        chk({tag, " ready"}, flag_out, occ > 0);
        if (occ > 0) chk({tag, " word"}, rd_data, exp_q[0]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // ---- standard timing, normal rewind ----
        do_mrst(1'b0, 1'b0);
        chk("R1 std empty", flag_out, 1);
        chk("R1 std full", flag_in, 0);
        chk("R1 std data", rd_data, 0);
        rd_std("R6 read empty");
        chk("R6 empty kept", flag_out, 1);
        for (int i = 0; i < DEPTH; i++) begin
            do_wr(W'(16'hA000 + i));
            chk("R3 not empty", flag_out, 0);
            chk("R3 full at depth", flag_in, (i == DEPTH - 1));
        end
        do_wr(16'hBEEF);
        chk("R6 full kept", flag_in, 1);
        for (int i = 0; i < DEPTH; i++) rd_std("R2 order");
        chk("R3 empty again", flag_out, 1);
        rd_std("R6 no underflow");
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        exp_q = hist; occ = hist.size();
        chk("R7 std hold", rd_data, 16'hA007);
        rd_std("R7 std first");
        rd_std("R7 std second");
        // ---- partial reset keeps standard timing ----
        do_prst();
        chk("R9 empty", flag_out, 1);
        chk("R9 data", rd_data, 0);
        do_wr(16'h5555);
        tick();
        chk("R9 mode kept", rd_data, 0);
        chk("R9 not empty", flag_out, 0);
        // ---- fall-through timing, normal rewind ----
        do_mrst(1'b1, 1'b0);
        chk("R1 fw ready", flag_out, 0);
        chk("R1 fw in", flag_in, 1);
        do_wr(16'h1111);
        chk("R4 not yet", flag_out, 0);
        do_wr(16'h2222);
        chk("R4 ready", flag_out, 1);
        chk("R4 word", rd_data, 16'h1111);
        do_wr(16'h3333);
        tick();
        chk("R5 held", rd_data, 16'h1111);
        rd_fw("R5 a"); rd_fw("R5 b"); rd_fw("R5 c");
        for (int i = 0; i < DEPTH; i++) do_wr(W'(16'hC000 + i));
        chk("R5 input not ready", flag_in, 0);
        do_wr(16'hDEAD);
        chk("R6 fw full", flag_in, 0);
        for (int i = 0; i < DEPTH; i++) rd_fw("R5 drain");
        chk("R5 in ready", flag_in, 1);
        do_prst();
        do_wr(16'h0A0A); do_wr(16'h0B0B); do_wr(16'h0C0C);
        tick();
        chk("R9 fw kept", rd_data, 16'h0A0A);
        rd_fw("R5 d");
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        exp_q = hist; occ = hist.size();
        chk("R7 fw drop", flag_out, 0);
        chk("R7 fw hold", rd_data, 16'h0B0B);
        tick();
        chk("R7 fw ready", flag_out, 1);
        chk("R7 fw first", rd_data, 16'h0A0A);
        rd_fw("R7 e"); rd_fw("R7 f"); rd_fw("R7 g");
        // ---- standard timing, zero-latency rewind with read ----
        do_mrst(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) do_wr(W'(16'hD000 + i));
        rd_std("R2 z a"); rd_std("R2 z b");
        rt_req = 1'b1; rd_en = 1'b1; tick(); rt_req = 1'b0; rd_en = 1'b0;
        exp_q = hist; last_word = exp_q.pop_front(); occ = hist.size() - 1;
        chk("R8 R10 same edge", rd_data, 16'hD000);
        rd_std("R8 next"); rd_std("R8 after");
        // ---- fall-through timing, zero-latency rewind ----
        do_mrst(1'b1, 1'b1);
        do_wr(16'hE000); do_wr(16'hE001); do_wr(16'hE002);
        tick();
        rd_fw("R5 z");
        rt_req = 1'b1; tick(); rt_req = 1'b0;
        exp_q = hist; occ = hist.size();
        chk("R8 fw ready", flag_out, 1);
        chk("R8 fw word", rd_data, 16'hE000);
        rd_fw("R8 h"); rd_fw("R8 i"); rd_fw("R8 j");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule